// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block holds the general-purpose registers and status state of a 32-bit processor that has several privileged operating modes. Sixteen architectural registers (index 0 to 15, index 15 being the program counter) are reached through two combinational read ports and one synchronous write port. Behind the architectural view sit more physical registers than architectural names. The current mode, kept in the live status word, decides which physical copy of registers 8 to 14 an access reaches. Registers 0 to 7 and 15 are the same physical registers in every mode.

Software-visible mode changes arrive on a mode-request input, or through a write of the live status word. Each exception-type mode also owns a saved status word, reached through its own read and write port. In modes that own no saved status word, that port falls back to the live status word. Decode, exception sequencing and flag computation live elsewhere. This block only stores, selects and tracks the mode.

Top module: `bankrf_top`

## Requirements
- R1: Both read ports return, in the same cycle, the register that their index selects in the bank of the current mode. A write takes effect at the next rising clock edge. There is no same-cycle bypass from the write port to a read port.
- R2: Indices 8 to 12 reach one shared set of physical registers in every mode except fast-interrupt mode (mode field 0x11), which reaches its own private set.
- R3: Indices 13 and 14 reach a separate bank in each of fast-interrupt (0x11), IRQ (0x12), supervisor (0x13), abort (0x17) and undefined (0x1B) mode. User (0x10), system (0x1F) and every other mode value share one further bank. Any other mode value also uses the shared set for indices 8 to 12.
- R4: Indices 0 to 7 and 15 reach the same physical registers in every mode.
- R5: A mode request takes the low 5 bits of the request and forces bit 4 to 1, with no other checking. For example, 0xE1 gives 0x11, 0x0F gives 0x1F and 0x05 gives the unrecognized mode 0x15. The new mode shows in the status word after the next rising edge.
- R6: The live status word has this layout: mode in bits [4:0], thumb bit 5, fast-interrupt disable bit 6, interrupt disable bit 7, and flags N, Z, C, V in bits 31 to 28. All other bits read 0. A write of the live status word keeps only these fields and forces bit 4 of the mode to 1, so a write of 0xFFFFFFFF reads back as 0xF00000FF.
- R7: A mode request that names the mode already active changes no register, no status word and no saved status word.
- R8: In user mode, system mode or any unrecognized mode value, a read of the saved-status port returns the live status word. A write there updates the live status word under the same rules as R6.
- R9: Modes 0x11, 0x12, 0x13, 0x17 and 0x1B each own a separate saved status word, with the same field mask as R6 and the mode bits stored as written. A write there leaves the live status word unchanged.
- R10: If a register write and a mode change happen in the same cycle, the write goes to the bank of the old mode.
- R11: After synchronous reset, the status word is 0x000000D3 (supervisor mode with both interrupt-disable bits set), and every register and saved status word reads 0.
- R12: In one cycle the mode request sets the mode field over any status write. A direct write of the live status word takes priority over a write that reaches it through the saved-status alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 4 | Architectural index, read port A |
| rd_a_data | output | DATA_W | Read data, port A (combinational) |
| rd_b_idx | input | 4 | Architectural index, read port B |
| rd_b_data | output | DATA_W | Read data, port B (combinational) |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 4 | Architectural index for the write |
| wr_data | input | DATA_W | Write data |
| mode_req_valid | input | 1 | Mode-change request strobe |
| mode_req | input | REQ_W | Requested mode (low 5 bits used) |
| psr_wr_en | input | 1 | Live status word write strobe |
| psr_wr_data | input | 32 | Live status word write data |
| spsr_wr_en | input | 1 | Saved status word write strobe |
| spsr_wr_data | input | 32 | Saved status word write data |
| psr_rd | output | 32 | Live status word |
| spsr_rd | output | 32 | Saved status word of the current mode, or the live word in modes without one |

## Verification
The bench builds the block with the default DATA_W of 32 and a REQ_W of 8. The three request bits above the 5-bit mode field can then carry junk. That shows that truncation and the forced bit 4 map such requests onto defined or unrecognized modes. With full 32-bit data, the masked status fields and the zero reserved range can be checked against all-ones writes. A long random phase drives all seven named modes and several unrecognized ones, in every pairing with register writes, so that the abort and undefined banks and the cross-mode ordering are covered beyond the directed cases.

// File: rtl/bankrf_pkg.sv
package bankrf_pkg;

  localparam int unsigned ARCH_N   = 16;
  localparam int unsigned IDX_W    = $clog2(ARCH_N);
  localparam int unsigned LOW_N    = 8;
  localparam int unsigned HIGH_N   = 5;
  localparam int unsigned SP_BANKS = 6;
  localparam int unsigned PHYS_N   = LOW_N + 2 * HIGH_N + 2 * SP_BANKS + 1;
  localparam int unsigned PHYS_W   = $clog2(PHYS_N);
  localparam int unsigned SPSR_N   = 5;
  localparam int unsigned SLOT_W   = 3;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;
  localparam logic [4:0] MODE_SYS = 5'h1F;

  typedef struct packed {
    logic       n;
    logic       z;
    logic       c;
    logic       v;
    logic       irq_off;
    logic       fiq_off;
    logic       thumb;
    logic [4:0] mode;
  } psr_t;

  function automatic logic [31:0] psr_pack(input psr_t p);
    return {p.n, p.z, p.c, p.v, 20'h0, p.irq_off, p.fiq_off, p.thumb, p.mode};
  endfunction

  function automatic psr_t psr_unpack(input logic [31:0] w);
    psr_t p;
    p.n       = w[31];
    p.z       = w[30];
    p.c       = w[29];
    p.v       = w[28];
    p.irq_off = w[7];
    p.fiq_off = w[6];
    p.thumb   = w[5];
    p.mode    = w[4:0];
    return p;
  endfunction

  function automatic logic [4:0] mode_force(input logic [4:0] m);
    return m | 5'h10;
  endfunction

  // bank number for indices 13/14; 0 is the user/system/unknown bank
  function automatic logic [2:0] sp_bank(input logic [4:0] m);
    case (m)
      MODE_FIQ: return 3'd1;
      MODE_IRQ: return 3'd2;
      MODE_SVC: return 3'd3;
      MODE_ABT: return 3'd4;
      MODE_UND: return 3'd5;
      default:  return 3'd0;
    endcase
  endfunction

  function automatic logic spsr_has(input logic [4:0] m);
    return sp_bank(m) != 3'd0;
  endfunction

  function automatic logic [SLOT_W-1:0] spsr_slot(input logic [4:0] m);
    return sp_bank(m) - 3'd1;
  endfunction

  // physical layout: 0-7 common low, 8-12 shared high, 13-17 fast-irq high,
  // 18-29 stack/link pairs per bank, 30 program counter
  function automatic logic [PHYS_W-1:0] phys_of(input logic [4:0] m,
                                                input logic [IDX_W-1:0] idx);
    int unsigned i;
    int unsigned p;
    i = int'(idx);
    if (i < LOW_N)
      p = i;
    else if (i < LOW_N + HIGH_N)
      p = (m == MODE_FIQ) ? (LOW_N + HIGH_N + i - LOW_N) : i;
    else if (i < ARCH_N - 1)
      p = LOW_N + 2 * HIGH_N + 2 * int'(sp_bank(m)) + (i - (LOW_N + HIGH_N));
    else
      p = PHYS_N - 1;
    return p[PHYS_W-1:0];
  endfunction

endpackage

// File: rtl/bankrf_map.sv
module bankrf_map
  import bankrf_pkg::*;
(
  input  logic [4:0]        mode,
  input  logic [IDX_W-1:0]  idx,
  output logic [PHYS_W-1:0] phys
);
  always_comb phys = phys_of(mode, idx);
endmodule

// File: rtl/bankrf_store.sv
module bankrf_store #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 31,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < int'(DEPTH); k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    rdata_a = mem[raddr_a];
    rdata_b = mem[raddr_b];
  end
endmodule

// File: rtl/bankrf_status.sv
module bankrf_status
  import bankrf_pkg::*;
#(
  parameter int unsigned REQ_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_req_valid,
  input  logic [REQ_W-1:0] mode_req,
  input  logic             psr_wr_en,
  input  logic [31:0]      psr_wr_data,
  input  logic             spsr_wr_en,
  input  logic [31:0]      spsr_wr_data,
  output logic [4:0]       cur_mode,
  output logic [31:0]      psr_rd,
  output logic [31:0]      spsr_rd
);
  psr_t              cpsr_q;
  psr_t              cpsr_n;
  psr_t              saved_q [SPSR_N];
  logic              has_saved;
  logic [SLOT_W-1:0] slot;
  logic [4:0]        req_mode;

  always_comb begin
    has_saved = spsr_has(cpsr_q.mode);
    slot      = spsr_slot(cpsr_q.mode);
    req_mode  = mode_force(mode_req[4:0]);
  end

  always_comb begin
    cpsr_n = cpsr_q;
    if (spsr_wr_en && !has_saved) begin
      cpsr_n      = psr_unpack(spsr_wr_data);
      cpsr_n.mode = mode_force(cpsr_n.mode);
    end
    if (psr_wr_en) begin
      cpsr_n      = psr_unpack(psr_wr_data);
      cpsr_n.mode = mode_force(cpsr_n.mode);
    end
    if (mode_req_valid) cpsr_n.mode = req_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpsr_q         <= '0;
      cpsr_q.irq_off <= 1'b1;
      cpsr_q.fiq_off <= 1'b1;
      cpsr_q.mode    <= MODE_SVC;
      for (int k = 0; k < int'(SPSR_N); k++) saved_q[k] <= '0;
    end else begin
      cpsr_q <= cpsr_n;
      if (spsr_wr_en && has_saved) saved_q[slot] <= psr_unpack(spsr_wr_data);
    end
  end

  always_comb begin
    cur_mode = cpsr_q.mode;
    psr_rd   = psr_pack(cpsr_q);
    spsr_rd  = has_saved ? psr_pack(saved_q[slot]) : psr_pack(cpsr_q);
  end
endmodule

// File: rtl/bankrf_top.sv
module bankrf_top
  import bankrf_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REQ_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mode_req_valid,
  input  logic [REQ_W-1:0]  mode_req,
  input  logic              psr_wr_en,
  input  logic [31:0]       psr_wr_data,
  input  logic              spsr_wr_en,
  input  logic [31:0]       spsr_wr_data,
  output logic [31:0]       psr_rd,
  output logic [31:0]       spsr_rd
);
  localparam int unsigned NLOOK = 3;

  logic [4:0]        cur_mode;
  logic [IDX_W-1:0]  look_idx  [NLOOK];
  logic [PHYS_W-1:0] look_phys [NLOOK];

  always_comb begin
    look_idx[0] = rd_a_idx;
    look_idx[1] = rd_b_idx;
    look_idx[2] = wr_idx;
  end

  for (genvar g = 0; g < NLOOK; g++) begin : g_look
    bankrf_map u_map (
      .mode (cur_mode),
      .idx  (look_idx[g]),
      .phys (look_phys[g])
    );
  end

  bankrf_status #(.REQ_W(REQ_W)) u_status (
    .clk            (clk),
    .rst            (rst),
    .mode_req_valid (mode_req_valid),
    .mode_req       (mode_req),
    .psr_wr_en      (psr_wr_en),
    .psr_wr_data    (psr_wr_data),
    .spsr_wr_en     (spsr_wr_en),
    .spsr_wr_data   (spsr_wr_data),
    .cur_mode       (cur_mode),
    .psr_rd         (psr_rd),
    .spsr_rd        (spsr_rd)
  );

  bankrf_store #(.DATA_W(DATA_W), .DEPTH(PHYS_N)) u_store (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .waddr   (look_phys[2]),
    .wdata   (wr_data),
    .raddr_a (look_phys[0]),
    .raddr_b (look_phys[1]),
    .rdata_a (rd_a_data),
    .rdata_b (rd_b_data)
  );
endmodule

// File: rtl/bankrf_chk.sv
module bankrf_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned REQ_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [3:0]        rd_a_idx,
  input logic [DATA_W-1:0] rd_a_data,
  input logic              wr_en,
  input logic [3:0]        wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic              mode_req_valid,
  input logic [REQ_W-1:0]  mode_req,
  input logic              psr_wr_en,
  input logic              spsr_wr_en,
  input logic [31:0]       psr_rd,
  input logic [31:0]       spsr_rd
);
  logic alias_mode;
  always_comb begin
    case (psr_rd[4:0])
      5'h11, 5'h12, 5'h13, 5'h17, 5'h1B: alias_mode = 1'b0;
      default:                           alias_mode = 1'b1;
    endcase
  end

  // R1: a plain write is visible one cycle later at the same index
  p_write_seen_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !mode_req_valid && !psr_wr_en && !spsr_wr_en)
    |=> (rd_a_idx != $past(wr_idx) || rd_a_data == $past(wr_data)));

  // R5: requested mode appears truncated with bit 4 set
  p_mode_forced_r5: assert property (@(posedge clk) disable iff (rst)
    mode_req_valid |=> psr_rd[4:0] == ($past(mode_req[4:0]) | 5'h10));

  // R6: reserved bits of the live word stay zero
  p_reserved_zero_r6: assert property (@(posedge clk) disable iff (rst)
    psr_rd[27:8] == 20'h0);

  // R7: same-mode request alone changes no status
  p_same_mode_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_req_valid && ((mode_req[4:0] | 5'h10) == psr_rd[4:0])
     && !psr_wr_en && !spsr_wr_en && !wr_en)
    |=> ($stable(psr_rd) && $stable(spsr_rd)));

  // R8: saved-status port aliases the live word where no saved copy exists
  p_alias_r8: assert property (@(posedge clk) disable iff (rst)
    alias_mode |-> spsr_rd == psr_rd);

  // R11: reset state of the live word
  p_reset_r11: assert property (@(posedge clk)
    rst |=> psr_rd == 32'h0000_00D3);
endmodule

bind bankrf_top bankrf_chk #(.DATA_W(DATA_W), .REQ_W(REQ_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .rd_a_idx       (rd_a_idx),
  .rd_a_data      (rd_a_data),
  .wr_en          (wr_en),
  .wr_idx         (wr_idx),
  .wr_data        (wr_data),
  .mode_req_valid (mode_req_valid),
  .mode_req       (mode_req),
  .psr_wr_en      (psr_wr_en),
  .spsr_wr_en     (spsr_wr_en),
  .psr_rd         (psr_rd),
  .spsr_rd        (spsr_rd)
);

// File: tb/test_bankrf_top.sv
module test_bankrf_top;
  localparam int DW = 32;
  localparam int RW = 8;
  localparam logic [31:0] MASK = 32'hF000_00FF;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [3:0]    rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [DW-1:0] rd_a_data, rd_b_data, wr_data = '0;
  logic          wr_en = 1'b0, mode_req_valid = 1'b0, psr_wr_en = 1'b0, spsr_wr_en = 1'b0;
  logic [RW-1:0] mode_req = '0;
  logic [31:0]   psr_wr_data = '0, spsr_wr_data = '0, psr_rd, spsr_rd;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  bankrf_top #(.DATA_W(DW), .REQ_W(RW)) i_bankrf_top (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .mode_req_valid(mode_req_valid), .mode_req(mode_req),
    .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
    .spsr_wr_en(spsr_wr_en), .spsr_wr_data(spsr_wr_data),
    .psr_rd(psr_rd), .spsr_rd(spsr_rd)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_reg  [int];
  logic [31:0] m_save [int];
  logic [31:0] m_cpsr;

  function automatic bit owns_save(input logic [4:0] m);
    return m == 5'h11 || m == 5'h12 || m == 5'h13 || m == 5'h17 || m == 5'h1B;
  endfunction

  function automatic int reg_key(input logic [4:0] m, input logic [3:0] idx);
    int i = int'(idx);
    if (i >= 8 && i <= 12) return (m == 5'h11) ? 100 + i : i;
    if (i == 13 || i == 14) return owns_save(m) ? 1000 * int'(m) + i : 500 + i;
    return i;
  endfunction

  function automatic logic [31:0] m_read(input logic [3:0] idx);
    int k = reg_key(m_cpsr[4:0], idx);
    return m_reg.exists(k) ? m_reg[k] : 32'h0;
  endfunction

  function automatic logic [31:0] m_saved();
    int k = int'(m_cpsr[4:0]);
    if (!owns_save(m_cpsr[4:0])) return m_cpsr;
    return m_save.exists(k) ? m_save[k] : 32'h0;
  endfunction

  task automatic model_edge();
    logic [4:0]  old;
    logic [31:0] nc;
    if (rst) begin
      m_reg.delete();
      m_save.delete();
      m_cpsr = 32'h0000_00D3;
    end else begin
      old = m_cpsr[4:0];
      if (wr_en) m_reg[reg_key(old, wr_idx)] = wr_data;
      nc = m_cpsr;
      if (spsr_wr_en) begin
        if (owns_save(old)) m_save[int'(old)] = spsr_wr_data & MASK;
        else nc = (spsr_wr_data & MASK) | 32'h10;
      end
      if (psr_wr_en) nc = (psr_wr_data & MASK) | 32'h10;
      if (mode_req_valid) nc[4:0] = mode_req[4:0] | 5'h10;
      m_cpsr = nc;
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R1 port A", rd_a_data, m_read(rd_a_idx));
    chk("R1 port B", rd_b_data, m_read(rd_b_idx));
    chk("R6 live word", psr_rd, m_cpsr);
    chk("R9 saved word", spsr_rd, m_saved());
    wr_en = 0; mode_req_valid = 0; psr_wr_en = 0; spsr_wr_en = 0;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; step();
  endtask

  task automatic req(input logic [7:0] m);
    mode_req_valid = 1; mode_req = m; step();
  endtask

  task automatic peek(input string tag, input logic [3:0] i, input logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i; step();
    chk(tag, rd_a_data, exp);
    chk(tag, rd_b_data, exp);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    step(); step();
    rst = 0;
    step();
    chk("R11 reset live word", psr_rd, 32'h0000_00D3);
    chk("R11 reset saved word", spsr_rd, 32'h0);
    peek("R11 reset reg8", 4'd8, 32'h0);
    peek("R11 reset reg13", 4'd13, 32'h0);

    wr(4'd8, 32'hA1A1_0008);
    wr(4'd13, 32'hB1B1_000D);
    wr(4'd0, 32'hC0C0_0000);
    wr(4'd15, 32'hD0D0_000F);

    req(8'hE1);
    chk("R5 request E1 gives 11", psr_rd, 32'h0000_00D1);
    peek("R2 fast-irq private reg8", 4'd8, 32'h0);
    peek("R3 fast-irq bank reg13", 4'd13, 32'h0);
    peek("R4 reg0 common", 4'd0, 32'hC0C0_0000);
    peek("R4 reg15 common", 4'd15, 32'hD0D0_000F);
    wr(4'd8, 32'hF8F8_0008);
    wr(4'd13, 32'hF13F_000D);

    req(8'h10);
    chk("R5 user mode", psr_rd, 32'h0000_00D0);
    peek("R2 shared reg8 back", 4'd8, 32'hA1A1_0008);
    peek("R3 user bank reg13 empty", 4'd13, 32'h0);
    wr(4'd13, 32'h5555_000D);

    req(8'h0F);
    chk("R5 request 0F gives 1F", psr_rd, 32'h0000_00DF);
    peek("R3 system shares user bank", 4'd13, 32'h5555_000D);

    req(8'hFF);
    chk("R7 same mode live word", psr_rd, 32'h0000_00DF);
    peek("R7 same mode reg13", 4'd13, 32'h5555_000D);

    chk("R8 alias read in system", spsr_rd, 32'h0000_00DF);
    spsr_wr_en = 1; spsr_wr_data = 32'hA000_0010; step();
    chk("R8 alias write live word", psr_rd, 32'hA000_0010);
    chk("R8 alias read after write", spsr_rd, 32'hA000_0010);

    psr_wr_en = 1; psr_wr_data = 32'hFFFF_FFFF; step();
    chk("R6 all-ones write masked", psr_rd, 32'hF000_00FF);
    psr_wr_en = 1; psr_wr_data = 32'h0000_0003; step();
    chk("R6 write forces bit 4", psr_rd, 32'h0000_0013);

    peek("R3 supervisor bank reg13", 4'd13, 32'hB1B1_000D);
    chk("R9 supervisor saved word zero", spsr_rd, 32'h0);
    spsr_wr_en = 1; spsr_wr_data = 32'h1234_5678; step();
    chk("R9 saved word masked", spsr_rd, 32'h1000_0078);
    chk("R9 live word unchanged", psr_rd, 32'h0000_0013);

    wr_en = 1; wr_idx = 4'd14; wr_data = 32'hE14E_000E;
    mode_req_valid = 1; mode_req = 8'h12; step();
    chk("R10 new mode next cycle", psr_rd, 32'h0000_0012);
    peek("R10 irq bank untouched", 4'd14, 32'h0);
    chk("R9 irq saved word separate", spsr_rd, 32'h0);
    req(8'h13);
    peek("R10 write landed in old bank", 4'd14, 32'hE14E_000E);
    chk("R9 supervisor saved word kept", spsr_rd, 32'h1000_0078);

    req(8'h05);
    chk("R5 request 05 gives 15", psr_rd, 32'h0000_0015);
    peek("R3 unknown mode uses user bank", 4'd13, 32'h5555_000D);
    peek("R2 unknown mode uses shared reg8", 4'd8, 32'hA1A1_0008);
    chk("R8 unknown mode alias", spsr_rd, 32'h0000_0015);

    psr_wr_en = 1; psr_wr_data = 32'h8000_001B;
    mode_req_valid = 1; mode_req = 8'h11; step();
    chk("R12 request beats status write mode", psr_rd, 32'h8000_0011);
    req(8'h10);
    psr_wr_en = 1; psr_wr_data = 32'h4000_0013;
    spsr_wr_en = 1; spsr_wr_data = 32'h2000_0017; step();
    chk("R12 direct write beats alias write", psr_rd, 32'h4000_0013);

    for (int n = 0; n < 4000; n++) begin
      logic [7:0] pick [8];
      pick = '{8'h10, 8'h11, 8'h12, 8'h13, 8'h17, 8'h1B, 8'h1F, 8'h00};
      rd_a_idx = 4'($urandom); rd_b_idx = 4'($urandom);
      wr_en = 1'($urandom); wr_idx = 4'($urandom); wr_data = $urandom;
      mode_req_valid = ($urandom % 4) == 0;
      mode_req = ($urandom % 8 == 0) ? 8'($urandom) : (pick[$urandom % 7] | 8'($urandom % 8) << 5);
      psr_wr_en = ($urandom % 16) == 0; psr_wr_data = $urandom;
      spsr_wr_en = ($urandom % 8) == 0; spsr_wr_data = $urandom;
      step();
    end

    rst = 1; step(); rst = 0;
    chk("R11 live word after mid-run reset", psr_rd, 32'h0000_00D3);
    peek("R11 reg8 after mid-run reset", 4'd8, 32'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule